// File: doc/BRIEF.md
# Two-Plane Flash Read Status Overlay

This block sits between the array read port and the data bus of a flash memory split into two planes. Each read strobe returns one word. When no embedded operation touches the plane or sector being read, the word is the array data unchanged. When the read hits a plane that is being programmed or erased, or hits a sector whose erase is on hold, bits 7, 6 and 2 of the low byte are replaced by status bits. Software polls these bits to find out when the operation ends. The block also drives an open-drain-style ready/busy line. The line is pulled low while an internal program or erase cycle runs and is left released at all other times.

Operation events come in as single-cycle pulses from the command logic. These are start of program, start of erase, suspend, resume and finish. A state machine tracks them through five states. ST_IDLE has no operation. ST_PROG has a program running. ST_ERASE has a sector erase running. ST_SUSP has the erase on hold. ST_SUSP_PROG has a program running while the erase is on hold.

The accepted transitions are:
- ST_IDLE to ST_PROG on a program start. A program start takes priority over an erase start in the same cycle.
- ST_IDLE to ST_ERASE on an erase start.
- ST_PROG to ST_IDLE on finish.
- ST_ERASE to ST_IDLE on finish. Finish takes priority over suspend in the same cycle.
- ST_ERASE to ST_SUSP on suspend.
- ST_SUSP to ST_SUSP_PROG on a program start. A program start takes priority over resume in the same cycle.
- ST_SUSP to ST_ERASE on resume.
- ST_SUSP_PROG to ST_SUSP on finish.

Every other event is ignored.

Top module: `dual_plane_status_rd`

## Requirements
- R1: After reset, rd_data is 0, rd_valid is 0 and rdy_drive_low is 0.
- R2: A read strobe sampled at a clock edge gives rd_valid high and the new rd_data right after that edge. Without a strobe, rd_valid is low and rd_data holds its value.
- R3: In ST_IDLE, and on any read of the plane with no running operation, rd_data equals array_data.
- R4: In ST_PROG, a read of the programming plane returns the following overrides on the low byte: bit 7 is the inverse of bit 7 of the programmed byte, bit 6 is the first toggle flop, and bit 2 is 1. All other bits are array data.
- R5: In ST_ERASE, a read of the erasing plane returns bit 7 as 0, bit 6 as the first toggle flop and bit 2 as the second toggle flop. After finish, reads return true data.
- R6: In ST_SUSP, a read whose sector equals the suspended sector returns bits 7 and 6 as 1 and bit 2 as the second toggle flop. A read of any other sector returns true data.
- R7: In ST_SUSP_PROG, a read of the programming plane returns bit 7 as the inverse of bit 7 of the programmed byte, bit 6 as the first toggle flop and bit 2 as the second toggle flop. A read of the suspended sector elsewhere follows the pattern in R6.
- R8: Both toggle flops load 0 when a program or erase start is accepted. A read shows each flop's current value and then inverts only the flops whose value it displayed. Reads that show true data do not advance either flop.
- R9: rdy_drive_low is 1 in ST_PROG, ST_ERASE and ST_SUSP_PROG, and 0 in ST_IDLE and ST_SUSP.
- R10: With byte_mode=1, rd_data[15:8] is 0. With byte_mode=0, rd_data[15:8] is always array_data[15:8], because status overrides touch only the low byte.
- R11: An erase start during ST_PROG and a program start during ST_ERASE are ignored. Reads keep showing the pattern of the running operation.
- R12: Suspend moves ST_ERASE to ST_SUSP. Finish moves ST_SUSP_PROG back to ST_SUSP. Resume moves ST_SUSP to ST_ERASE and leaves the toggle flops unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Pulse: a program operation starts |
| start_erase | input | 1 | Pulse: a sector erase starts |
| suspend | input | 1 | Pulse: put the running erase on hold |
| resume | input | 1 | Pulse: continue the held erase |
| finish | input | 1 | Pulse: the running embedded operation is complete |
| prog_plane | input | PW (1) | Plane of the program, sampled on start_prog |
| prog_byte | input | 8 | Low byte being programmed, sampled on start_prog |
| erase_plane | input | PW (1) | Plane of the erase, sampled on start_erase |
| erase_sector | input | SW (6) | Sector being erased, sampled on start_erase |
| rd_strobe | input | 1 | One pulse per read access |
| rd_plane | input | PW (1) | Plane addressed by the read |
| rd_sector | input | SW (6) | Sector addressed by the read |
| array_data | input | DW (16) | Word fetched from the array |
| byte_mode | input | 1 | 1 selects the 8-bit bus; the upper byte is forced to 0 |
| rd_data | output | DW (16) | Returned read word |
| rd_valid | output | 1 | High for one cycle with each returned word |
| rdy_drive_low | output | 1 | 1 pulls the ready/busy line low; 0 releases it |

## Verification
Each stored context field shows up directly in the polled bits. A wrong state register or a lost transition changes the pattern on bits 7, 6 and 2 of the very next read. It also changes rdy_drive_low one cycle after the event. A stale plane or sector register moves the status pattern onto reads that should return true data. A toggle flop that fails to load or to advance breaks the 0,1,0 sequence by the second read of the busy plane. Reads interleaved between the planes show whether reads of the idle plane leave the sequence untouched.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG
    } op_state_e;

    // Low-byte overlay: which status bits replace array data, their values,
    // and which toggle flops the read consumes.
    typedef struct packed {
        logic ovr7;
        logic ovr6;
        logic ovr2;
        logic v7;
        logic v6;
        logic v2;
        logic adv6;
        logic adv2;
    } status_ovl_t;

endpackage

// File: rtl/fsr_op_fsm.sv
module fsr_op_fsm
    import fsr_pkg::*;
#(
    parameter int PW = 1,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          suspend,
    input  logic          resume,
    input  logic          finish,
    input  logic [PW-1:0] prog_plane_in,
    input  logic          prog_msb_in,
    input  logic [PW-1:0] erase_plane_in,
    input  logic [SW-1:0] erase_sector_in,
    output op_state_e     state,
    output logic [PW-1:0] prog_plane_q,
    output logic          prog_msb_q,
    output logic [PW-1:0] erase_plane_q,
    output logic [SW-1:0] erase_sector_q,
    output logic          op_load,
    output logic          busy
);

    op_state_e nxt_state;
    logic      take_prog;
    logic      take_erase;

    // Next-state and event acceptance.
    always_comb begin
        nxt_state  = state;
        take_prog  = 1'b0;
        take_erase = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_prog) begin
                    nxt_state = ST_PROG;
                    take_prog = 1'b1;
                end else if (start_erase) begin
                    nxt_state  = ST_ERASE;
                    take_erase = 1'b1;
                end
            end
            ST_PROG: begin
                if (finish) nxt_state = ST_IDLE;
            end
            ST_ERASE: begin
                if (finish)       nxt_state = ST_IDLE;
                else if (suspend) nxt_state = ST_SUSP;
            end
            ST_SUSP: begin
                if (start_prog) begin
                    nxt_state = ST_SUSP_PROG;
                    take_prog = 1'b1;
                end else if (resume) begin
                    nxt_state = ST_ERASE;
                end
            end
            ST_SUSP_PROG: begin
                if (finish) nxt_state = ST_SUSP;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State and context registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            prog_plane_q   <= '0;
            prog_msb_q     <= 1'b0;
            erase_plane_q  <= '0;
            erase_sector_q <= '0;
        end else begin
            state <= nxt_state;
            if (take_prog) begin
                prog_plane_q <= prog_plane_in;
                prog_msb_q   <= prog_msb_in;
            end
            if (take_erase) begin
                erase_plane_q  <= erase_plane_in;
                erase_sector_q <= erase_sector_in;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        op_load = take_prog | take_erase;
        unique case (state)
            ST_PROG, ST_ERASE, ST_SUSP_PROG: busy = 1'b1;
            default:                         busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsr_toggle_pair.sv
module fsr_toggle_pair #(
    parameter int NUM_TGL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_TGL-1:0] adv,
    output logic [NUM_TGL-1:0] q
);

    for (genvar g = 0; g < NUM_TGL; g++) begin : g_tgl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[g] <= 1'b0;
            else if (load)   q[g] <= 1'b0;
            else if (adv[g]) q[g] <= ~q[g];
        end
    end

endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
    import fsr_pkg::*;
#(
    parameter int PW = 1,
    parameter int SW = 6
) (
    input  op_state_e     state,
    input  logic [PW-1:0] rd_plane,
    input  logic [SW-1:0] rd_sector,
    input  logic [PW-1:0] prog_plane,
    input  logic          prog_msb,
    input  logic [PW-1:0] erase_plane,
    input  logic [SW-1:0] erase_sector,
    input  logic          tgl6,
    input  logic          tgl2,
    output status_ovl_t   ovl
);

    logic hit_prog;
    logic hit_erase_plane;
    logic hit_held_sector;

    assign hit_prog        = (rd_plane == prog_plane);
    assign hit_erase_plane = (rd_plane == erase_plane);
    assign hit_held_sector = (rd_sector == erase_sector);

    always_comb begin
        ovl = '0;
        unique case (state)
            ST_IDLE: ovl = '0;
            ST_PROG: begin
                if (hit_prog) begin
                    ovl.ovr7 = 1'b1; ovl.v7 = ~prog_msb;
                    ovl.ovr6 = 1'b1; ovl.v6 = tgl6; ovl.adv6 = 1'b1;
                    ovl.ovr2 = 1'b1; ovl.v2 = 1'b1;
                end
            end
            ST_ERASE: begin
                if (hit_erase_plane) begin
                    ovl.ovr7 = 1'b1; ovl.v7 = 1'b0;
                    ovl.ovr6 = 1'b1; ovl.v6 = tgl6; ovl.adv6 = 1'b1;
                    ovl.ovr2 = 1'b1; ovl.v2 = tgl2; ovl.adv2 = 1'b1;
                end
            end
            ST_SUSP: begin
                if (hit_held_sector) begin
                    ovl.ovr7 = 1'b1; ovl.v7 = 1'b1;
                    ovl.ovr6 = 1'b1; ovl.v6 = 1'b1;
                    ovl.ovr2 = 1'b1; ovl.v2 = tgl2; ovl.adv2 = 1'b1;
                end
            end
            ST_SUSP_PROG: begin
                if (hit_prog) begin
                    ovl.ovr7 = 1'b1; ovl.v7 = ~prog_msb;
                    ovl.ovr6 = 1'b1; ovl.v6 = tgl6; ovl.adv6 = 1'b1;
                    ovl.ovr2 = 1'b1; ovl.v2 = tgl2; ovl.adv2 = 1'b1;
                end else if (hit_held_sector) begin
                    ovl.ovr7 = 1'b1; ovl.v7 = 1'b1;
                    ovl.ovr6 = 1'b1; ovl.v6 = 1'b1;
                    ovl.ovr2 = 1'b1; ovl.v2 = tgl2; ovl.adv2 = 1'b1;
                end
            end
            default: ovl = '0;
        endcase
    end

endmodule

// File: rtl/dual_plane_status_rd.sv
module dual_plane_status_rd
    import fsr_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 1,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          suspend,
    input  logic          resume,
    input  logic          finish,
    input  logic [PW-1:0] prog_plane,
    input  logic [7:0]    prog_byte,
    input  logic [PW-1:0] erase_plane,
    input  logic [SW-1:0] erase_sector,
    input  logic          rd_strobe,
    input  logic [PW-1:0] rd_plane,
    input  logic [SW-1:0] rd_sector,
    input  logic [DW-1:0] array_data,
    input  logic          byte_mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rdy_drive_low
);

    localparam int HI_W = DW - 8;

    op_state_e     cur_state;
    logic [PW-1:0] prog_plane_q;
    logic          prog_msb_q;
    logic [PW-1:0] erase_plane_q;
    logic [SW-1:0] erase_sector_q;
    logic          op_load;
    logic [1:0]    tgl_q;
    logic [1:0]    tgl_adv;
    status_ovl_t   ovl;
    logic [7:0]    lo_byte;
    logic [HI_W-1:0] hi_byte;

    fsr_op_fsm #(.PW(PW), .SW(SW)) i_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_prog      (start_prog),
        .start_erase     (start_erase),
        .suspend         (suspend),
        .resume          (resume),
        .finish          (finish),
        .prog_plane_in   (prog_plane),
        .prog_msb_in     (prog_byte[7]),
        .erase_plane_in  (erase_plane),
        .erase_sector_in (erase_sector),
        .state           (cur_state),
        .prog_plane_q    (prog_plane_q),
        .prog_msb_q      (prog_msb_q),
        .erase_plane_q   (erase_plane_q),
        .erase_sector_q  (erase_sector_q),
        .op_load         (op_load),
        .busy            (rdy_drive_low)
    );

    fsr_status_mux #(.PW(PW), .SW(SW)) i_mux (
        .state        (cur_state),
        .rd_plane     (rd_plane),
        .rd_sector    (rd_sector),
        .prog_plane   (prog_plane_q),
        .prog_msb     (prog_msb_q),
        .erase_plane  (erase_plane_q),
        .erase_sector (erase_sector_q),
        .tgl6         (tgl_q[1]),
        .tgl2         (tgl_q[0]),
        .ovl          (ovl)
    );

    assign tgl_adv = {rd_strobe & ovl.adv6, rd_strobe & ovl.adv2};

    fsr_toggle_pair #(.NUM_TGL(2)) i_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op_load),
        .adv   (tgl_adv),
        .q     (tgl_q)
    );

    always_comb begin
        lo_byte    = array_data[7:0];
        if (ovl.ovr7) lo_byte[7] = ovl.v7;
        if (ovl.ovr6) lo_byte[6] = ovl.v6;
        if (ovl.ovr2) lo_byte[2] = ovl.v2;
        hi_byte    = byte_mode ? '0 : array_data[DW-1:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_strobe;
            if (rd_strobe) rd_data <= {hi_byte, lo_byte};
        end
    end

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 1,
    parameter int SW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_prog,
    input logic          suspend,
    input logic          finish,
    input logic          rd_strobe,
    input logic [PW-1:0] rd_plane,
    input logic [SW-1:0] rd_sector,
    input logic [DW-1:0] array_data,
    input logic          byte_mode,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          rdy_drive_low,
    input op_state_e     cur_state,
    input logic [PW-1:0] prog_plane_q,
    input logic [PW-1:0] erase_plane_q,
    input logic [SW-1:0] erase_sector_q
);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid); // R2
    AST_IDLE_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cur_state == ST_IDLE && !byte_mode) |=> rd_data == $past(array_data)); // R3
    AST_PROG_B2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cur_state == ST_PROG && rd_plane == prog_plane_q) |=> rd_data[2]); // R4
    AST_ERASE_B7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cur_state == ST_ERASE && rd_plane == erase_plane_q) |=> !rd_data[7]); // R5
    AST_HELD_SECTOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cur_state == ST_SUSP && rd_sector == erase_sector_q) |=> rd_data[7:6] == 2'b11); // R6
    AST_START_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && start_prog) |=> rdy_drive_low); // R9
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && byte_mode) |=> rd_data[DW-1:8] == '0); // R10
    AST_SUSPEND_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ERASE && suspend && !finish) |=> !rdy_drive_low); // R12

endmodule

bind dual_plane_status_rd fsr_checker #(.DW(DW), .PW(PW), .SW(SW)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_prog     (start_prog),
    .suspend        (suspend),
    .finish         (finish),
    .rd_strobe      (rd_strobe),
    .rd_plane       (rd_plane),
    .rd_sector      (rd_sector),
    .array_data     (array_data),
    .byte_mode      (byte_mode),
    .rd_data        (rd_data),
    .rd_valid       (rd_valid),
    .rdy_drive_low  (rdy_drive_low),
    .cur_state      (cur_state),
    .prog_plane_q   (prog_plane_q),
    .erase_plane_q  (erase_plane_q),
    .erase_sector_q (erase_sector_q)
);

// File: tb/test_dual_plane_status_rd.sv
`timescale 1ns/1ps
module test_dual_plane_status_rd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_prog = 0, start_erase = 0, suspend = 0, resume = 0, finish = 0;
    logic [0:0]  prog_plane = '0;
    logic [7:0]  prog_byte = '0;
    logic [0:0]  erase_plane = '0;
    logic [5:0]  erase_sector = '0;
    logic        rd_strobe = 0;
    logic [0:0]  rd_plane = '0;
    logic [5:0]  rd_sector = '0;
    logic [15:0] array_data = '0;
    logic        byte_mode = 0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rdy_drive_low;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dual_plane_status_rd i_dual_plane_status_rd (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .suspend(suspend), .resume(resume), .finish(finish),
        .prog_plane(prog_plane), .prog_byte(prog_byte),
        .erase_plane(erase_plane), .erase_sector(erase_sector),
        .rd_strobe(rd_strobe), .rd_plane(rd_plane), .rd_sector(rd_sector),
        .array_data(array_data), .byte_mode(byte_mode),
        .rd_data(rd_data), .rd_valid(rd_valid), .rdy_drive_low(rdy_drive_low)
    );

    function automatic logic [15:0] mix(input logic [15:0] a, input logic b7,
                                        input logic b6, input logic b2);
        return {a[15:8], b7, b6, a[5:3], b2, a[1:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one read strobe, expected word pushed to the scoreboard.
    task automatic do_read(input logic p, input logic [5:0] s, input logic [15:0] a,
                           input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_strobe = 1; rd_plane = p; rd_sector = s; array_data = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_strobe = 0;
    endtask

    task automatic ev_prog(input logic p, input logic [7:0] b);
        @(negedge clk); start_prog = 1; prog_plane = p; prog_byte = b;
        @(negedge clk); start_prog = 0;
    endtask
    task automatic ev_erase(input logic p, input logic [5:0] s);
        @(negedge clk); start_erase = 1; erase_plane = p; erase_sector = s;
        @(negedge clk); start_erase = 0;
    endtask
    task automatic ev_suspend();
        @(negedge clk); suspend = 1; @(negedge clk); suspend = 0;
    endtask
    task automatic ev_resume();
        @(negedge clk); resume = 1; @(negedge clk); resume = 0;
    endtask
    task automatic ev_finish();
        @(negedge clk); finish = 1; @(negedge clk); finish = 0;
    endtask

    // Monitor: pops the scoreboard for each returned word.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    localparam logic [15:0] A0 = 16'h5A3B;
    localparam logic [15:0] A1 = 16'hC33B;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data reset", rd_data, 16'h0);
        check("R1 rd_valid reset", {15'b0, rd_valid}, 16'h0);
        check("R1 busy reset", {15'b0, rdy_drive_low}, 16'h0);
        rst_n = 1;
        @(negedge clk);

        do_read(0, 6'd3, 16'h123B, 16'h123B, "R3 idle read");
        @(negedge clk);
        check("R2 valid drops", {15'b0, rd_valid}, 16'h0);
        check("R2 data held", rd_data, 16'h123B);

        // Program on plane 0, programmed byte bit 7 = 1
        ev_prog(0, 8'h80);
        check("R9 busy in program", {15'b0, rdy_drive_low}, 16'h1);
        do_read(0, 6'd3, A0, mix(A0, 0, 0, 1), "R4 R8 prog read 1");
        do_read(1, 6'd20, A1, A1, "R3 other plane during prog");
        do_read(0, 6'd3, A0, mix(A0, 0, 1, 1), "R4 R10 prog read 2");
        do_read(0, 6'd4, A1, mix(A1, 0, 0, 1), "R4 R8 prog read 3");
        ev_erase(1, 6'd20);
        do_read(0, 6'd3, A0, mix(A0, 0, 1, 1), "R11 erase start ignored in prog");
        ev_finish();
        check("R9 released after prog", {15'b0, rdy_drive_low}, 16'h0);
        do_read(0, 6'd3, A0, A0, "R5 true data after finish");

        // Erase sector 20 on plane 1
        ev_erase(1, 6'd20);
        check("R9 busy in erase", {15'b0, rdy_drive_low}, 16'h1);
        do_read(1, 6'd20, A1, mix(A1, 0, 0, 0), "R5 R8 erase read 1");
        do_read(1, 6'd21, A1, mix(A1, 0, 1, 1), "R5 erase read 2");
        do_read(0, 6'd3, A0, A0, "R3 R8 other plane during erase");
        do_read(1, 6'd20, A1, mix(A1, 0, 0, 0), "R5 R8 erase read 3");
        ev_prog(0, 8'h00);
        do_read(1, 6'd20, A1, mix(A1, 0, 1, 1), "R11 prog start ignored in erase");

        ev_suspend();
        check("R9 R12 released when held", {15'b0, rdy_drive_low}, 16'h0);
        do_read(1, 6'd20, A1, mix(A1, 1, 1, 0), "R6 held sector read 1");
        do_read(1, 6'd20, A1, mix(A1, 1, 1, 1), "R6 held sector read 2");
        do_read(1, 6'd21, A1, A1, "R6 other sector during hold");

        ev_prog(0, 8'h00);
        check("R9 busy in held program", {15'b0, rdy_drive_low}, 16'h1);
        do_read(0, 6'd3, A0, mix(A0, 1, 0, 0), "R7 R8 held prog read 1");
        do_read(0, 6'd3, A0, mix(A0, 1, 1, 1), "R7 held prog read 2");
        do_read(1, 6'd20, A1, mix(A1, 1, 1, 0), "R7 held sector during prog");
        do_read(1, 6'd22, A1, A1, "R7 other sector during held prog");

        ev_finish();
        check("R12 back to hold", {15'b0, rdy_drive_low}, 16'h0);
        do_read(0, 6'd3, A0, A0, "R12 true data in hold");

        ev_resume();
        check("R12 busy after resume", {15'b0, rdy_drive_low}, 16'h1);
        do_read(1, 6'd25, A1, mix(A1, 0, 0, 1), "R12 R8 resume keeps toggles");
        ev_finish();
        check("R9 released after erase", {15'b0, rdy_drive_low}, 16'h0);

        byte_mode = 1;
        do_read(0, 6'd3, 16'hAB3B, 16'h003B, "R10 byte mode upper zero");
        byte_mode = 0;

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule